// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Line Allocation

This block is a direct-mapped data cache placed between a processor and a slower, word-addressed main memory, both with 32-bit data. By default it keeps 1024 lines, each four 32-bit words wide, for 16 KB of data. Each processor request carries a byte address. The block takes the low four bits as the position inside a line, the next ten bits as the line number, and the upper eighteen bits as the tag. It then looks at the one line that address can live in.

A read that finds its line valid and tagged with the same upper bits completes in the cycle it is presented. Any other read stalls the processor while the whole line is brought in from memory, one word per memory transfer. The request is then looked up again and completes as a hit. Every store is written through to memory. A store that misses first brings its line in exactly as a read miss would, and only then merges the stored word into the cache.

Two event counters record how many requests hit and how many missed, so that a surrounding test environment can compare hit-rate behaviour with a reference model.

Top module: `dm_wa_cache`

## Requirements
- R1: For byte address A, the line number is A[13:4] (ten bits, INDEX_W in general), the tag is A[31:14], and A[3:2] selects the word in the line. Two addresses with the same line number and different tags evict each other, so each access after the other one is a miss.
- R2: A read whose line is valid with an equal stored tag asserts cpuReady in the same cycle as the request, with cpuRdata holding the word, and it issues no memory transfer.
- R3: On a read miss, cpuReady stays low while exactly four memory reads fetch words 0, 1, 2, 3 in that order, at word address {tag, line number, word}. The line is then installed and the request completes with the requested word.
- R4: A store that hits updates the cached word and performs exactly one memory write of cpuWdata at word address A[31:2]. cpuReady is raised in the cycle that memory acknowledges the write.
- R5: A store that misses first fetches the whole line as in R3, then merges the stored word and writes it through to memory. Later reads of the line return the stored word and the memory contents of the other words.
- R6: From the cycle a miss is detected until the line fill ends, cpuReady is held low and no new request is accepted.
- R7: Reset invalidates every line and clears both counters, so the first access to any address after reset is a miss.
- R8: Address bits 1:0 are ignored. Requests that differ only in those bits hit the same word.
- R9: Each completed request adds exactly one to either hitCount (when its first lookup hit) or missCount (when it did not). The counters never change together.
- R10: Once memReq is raised, memReq, memWe and memAddr stay unchanged until memValid is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Request completes in this cycle |
| cpuRdata | output | DATA_W | Load data, valid with cpuReady on a load |
| memReq | output | 1 | Memory transfer request, held until memValid |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W-2 | Word address to memory |
| memWdata | output | DATA_W | Memory write data |
| memValid | input | 1 | One-cycle acknowledge; carries read data on reads |
| memRdata | input | DATA_W | Memory read data |
| hitCount | output | CNT_W | Number of requests that hit |
| missCount | output | CNT_W | Number of requests that missed |

## Verification
The bench builds the cache with INDEX_W = 2, which gives four lines of four words and a 26-bit tag. With so few lines, every line gets filled, evicted and refilled many times within a few hundred accesses, and tags 0 to 3 produce constant conflicts. A memory model with a fixed two-cycle acknowledge delay makes the stall length of a fill predictable. A shadow copy of memory and a shadow tag/valid table in the bench give the expected data and the expected hit or miss for every request. The bench runs structured sweeps over every line and word, then a long pseudo-random mix of loads and stores.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_STORE = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic addrFill;  // memory address uses the fill word counter
    logic fillWe;    // write returned memory word into the line
    logic fillDone;  // install tag and set valid
    logic storeWe;   // merge processor store word into the line
    logic cntHit;    // count a hit
    logic cntMiss;   // count a miss
  } ctrlStrobe_t;

endpackage

// File: rtl/dmc_datapath.sv
`timescale 1ns/1ps
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int INDEX_W    = 10,
  parameter int LINE_WORDS = 4,
  parameter int CNT_W      = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 cpuAddr,
  input  logic [DATA_W-1:0]                 cpuWdata,
  input  logic [DATA_W-1:0]                 memRdata,
  input  ctrlStrobe_t                       strobe,
  input  logic [$clog2(LINE_WORDS)-1:0]     fillWord,
  output logic                              lookupHit,
  output logic [DATA_W-1:0]                 cpuRdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  output logic [CNT_W-1:0]                  hitCount,
  output logic [CNT_W-1:0]                  missCount
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W;
  localparam int LINES  = 1 << INDEX_W;

  logic [TAG_W-1:0]   reqTag;
  logic [INDEX_W-1:0] reqIndex;
  logic [WSEL_W-1:0]  reqWord;
  logic [BYTE_W-1:0]  unusedLowBits;

  assign reqTag        = cpuAddr[ADDR_W-1 -: TAG_W];
  assign reqIndex      = cpuAddr[OFF_W +: INDEX_W];
  assign reqWord       = cpuAddr[BYTE_W +: WSEL_W];
  assign unusedLowBits = cpuAddr[BYTE_W-1:0];

  logic [LINES-1:0]  validBits;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES][LINE_WORDS];

  // Valid bits are the only storage that needs a reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      validBits <= '0;
    end else if (strobe.fillDone) begin
      validBits[reqIndex] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillDone) begin
      tagMem[reqIndex] <= reqTag;
    end
    if (strobe.fillWe) begin
      dataMem[reqIndex][fillWord] <= memRdata;
    end
    if (strobe.storeWe) begin
      dataMem[reqIndex][reqWord] <= cpuWdata;
    end
  end

  assign lookupHit = validBits[reqIndex] && (tagMem[reqIndex] == reqTag);
  assign cpuRdata  = dataMem[reqIndex][reqWord];
  assign memAddr   = strobe.addrFill ? {reqTag, reqIndex, fillWord}
                                     : {reqTag, reqIndex, reqWord};

  always_ff @(posedge clk) begin
    if (rst) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (strobe.cntHit)  hitCount  <= hitCount  + CNT_W'(1);
      if (strobe.cntMiss) missCount <= missCount + CNT_W'(1);
    end
  end

  // R9: a single request never counts as both a hit and a miss
  assert_one_event_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({strobe.cntHit, strobe.cntMiss}) <= 1);

  // R3: once a line is installed, the held request finds it
  assert_install_hit_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.fillDone |=> lookupHit);

  // R5: a store is merged only into a line that is present
  assert_merge_present_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.storeWe |-> lookupHit);

endmodule

// File: rtl/dmc_control.sv
`timescale 1ns/1ps
module dmc_control
  import dmc_pkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpuReq,
  input  logic                          cpuWe,
  input  logic                          lookupHit,
  input  logic                          memValid,
  output ctrlStrobe_t                   strobe,
  output logic [$clog2(LINE_WORDS)-1:0] fillWord,
  output logic                          cpuReady,
  output logic                          memReq,
  output logic                          memWe
);

  localparam int WSEL_W = $clog2(LINE_WORDS);

  ctrlState_t        state;
  ctrlState_t        nextState;
  logic [WSEL_W-1:0] fillCnt;
  logic              replay;
  logic              lastWord;

  assign fillWord = fillCnt;
  assign lastWord = (fillCnt == WSEL_W'(LINE_WORDS - 1));

  always_comb begin
    strobe    = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (lookupHit) begin
            strobe.cntHit = !replay;
            if (cpuWe) begin
              nextState = ST_STORE;
            end else begin
              cpuReady = 1'b1;
            end
          end else begin
            strobe.cntMiss = 1'b1;
            nextState      = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq          = 1'b1;
        strobe.addrFill = 1'b1;
        if (memValid) begin
          strobe.fillWe = 1'b1;
          if (lastWord) begin
            strobe.fillDone = 1'b1;
            nextState       = ST_IDLE;
          end
        end
      end
      ST_STORE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memValid) begin
          strobe.storeWe = 1'b1;
          cpuReady       = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      fillCnt <= '0;
      replay  <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.fillWe) fillCnt <= fillCnt + WSEL_W'(1);
      if (strobe.cntMiss)  replay <= 1'b1;
      else if (cpuReady)   replay <= 1'b0;
    end
  end

  // R6: the processor is never released while a fill is running
  assert_fill_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |-> !cpuReady);

  // R6: a fill always begins on word zero
  assert_fill_start_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.cntMiss |=> (fillCnt == '0));

endmodule

// File: rtl/dm_wa_cache.sv
`timescale 1ns/1ps
module dm_wa_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int INDEX_W    = 10,
  parameter int LINE_WORDS = 4,
  parameter int CNT_W      = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cpuReq,
  input  logic                                cpuWe,
  input  logic [ADDR_W-1:0]                   cpuAddr,
  input  logic [DATA_W-1:0]                   cpuWdata,
  output logic                                cpuReady,
  output logic [DATA_W-1:0]                   cpuRdata,
  output logic                                memReq,
  output logic                                memWe,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  memAddr,
  output logic [DATA_W-1:0]                   memWdata,
  input  logic                                memValid,
  input  logic [DATA_W-1:0]                   memRdata,
  output logic [CNT_W-1:0]                    hitCount,
  output logic [CNT_W-1:0]                    missCount
);

  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WSEL_W  = $clog2(LINE_WORDS);
  localparam int MADDR_W = ADDR_W - BYTE_W;

  ctrlStrobe_t       strobe;
  logic [WSEL_W-1:0] fillWord;
  logic              lookupHit;

  assign memWdata = cpuWdata;

  dmc_control #(
    .LINE_WORDS (LINE_WORDS)
  ) u_control (
    .clk       (clk),
    .rst       (rst),
    .cpuReq    (cpuReq),
    .cpuWe     (cpuWe),
    .lookupHit (lookupHit),
    .memValid  (memValid),
    .strobe    (strobe),
    .fillWord  (fillWord),
    .cpuReady  (cpuReady),
    .memReq    (memReq),
    .memWe     (memWe)
  );

  dmc_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .INDEX_W    (INDEX_W),
    .LINE_WORDS (LINE_WORDS),
    .CNT_W      (CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .memRdata  (memRdata),
    .strobe    (strobe),
    .fillWord  (fillWord),
    .lookupHit (lookupHit),
    .cpuRdata  (cpuRdata),
    .memAddr   (memAddr),
    .hitCount  (hitCount),
    .missCount (missCount)
  );

  // R10: a memory request is held steady until it is acknowledged
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
    memReq && !memValid |=> memReq && $stable(memAddr) && $stable(memWe));

  // R3: consecutive fill reads step through the line in ascending order
  assert_fill_ascending_R3: assert property (@(posedge clk) disable iff (rst)
    memReq && !memWe && memValid &&
    (memAddr[WSEL_W-1:0] != WSEL_W'(LINE_WORDS - 1))
    |=> memReq && !memWe && (memAddr == $past(memAddr) + MADDR_W'(1)));

  // R4: a store completes only together with its memory write acknowledge
  assert_write_through_R4: assert property (@(posedge clk) disable iff (rst)
    cpuReady && cpuWe |-> memReq && memWe && memValid);

  // R2: a completing load is never paired with memory traffic
  assert_read_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cpuReady && !cpuWe |-> !memReq);

endmodule

// File: tb/dm_wa_cache_bench.sv
`timescale 1ns/1ps
module dm_wa_cache_bench;

  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int INDEX_W    = 2;
  localparam int LINE_WORDS = 4;
  localparam int CNT_W      = 16;
  localparam int OFF_W      = 4;
  localparam int TAG_W      = ADDR_W - INDEX_W - OFF_W;
  localparam int LINES      = 1 << INDEX_W;
  localparam int LAT        = 2;
  localparam int MAX_CYCLES = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpuReq = 1'b0;
  logic              cpuWe = 1'b0;
  logic [31:0]       cpuAddr = '0;
  logic [31:0]       cpuWdata = '0;
  logic              cpuReady;
  logic [31:0]       cpuRdata;
  logic              memReq;
  logic              memWe;
  logic [29:0]       memAddr;
  logic [31:0]       memWdata;
  logic              memValid;
  logic [31:0]       memRdata;
  logic [CNT_W-1:0]  hitCount;
  logic [CNT_W-1:0]  missCount;

  always #4 clk = ~clk;

  dm_wa_cache #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W),
    .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)
  ) u_dm_wa_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memValid(memValid), .memRdata(memRdata), .hitCount(hitCount),
    .missCount(missCount)
  );

  // ---------------- memory model ----------------
  logic [31:0] memStore [logic [29:0]];
  logic [31:0] shadow   [logic [29:0]];
  logic [29:0] rdLog [4];
  logic [31:0] rdCount = '0;
  logic [31:0] wrCount = '0;
  logic [31:0] holdViol = '0;
  logic [3:0]  latCnt = '0;
  logic        prevPend = 1'b0;
  logic [29:0] prevAddr = '0;
  logic        prevWe = 1'b0;

  function automatic logic [31:0] initWord(input logic [29:0] a);
    return ({2'b00, a} * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      memValid <= 1'b0;
      latCnt   <= '0;
      prevPend <= 1'b0;
    end else begin
      if (prevPend && (!memReq || memAddr != prevAddr || memWe != prevWe))
        holdViol <= holdViol + 32'd1;
      prevPend <= memReq && !memValid;
      prevAddr <= memAddr;
      prevWe   <= memWe;
      if (memReq && !memValid) begin
        if (latCnt == 4'(LAT)) begin
          memValid <= 1'b1;
          latCnt   <= '0;
          if (memWe) begin
            memStore[memAddr] = memWdata;
            wrCount <= wrCount + 32'd1;
          end else begin
            memRdata <= memStore.exists(memAddr) ? memStore[memAddr] : initWord(memAddr);
            rdLog[rdCount[1:0]] <= memAddr;
            rdCount <= rdCount + 32'd1;
          end
        end else begin
          latCnt <= latCnt + 4'd1;
        end
      end else begin
        memValid <= 1'b0;
        latCnt   <= '0;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic             refValid [LINES];
  logic [TAG_W-1:0] refTag   [LINES];

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [29:0] a);
    return shadow.exists(a) ? shadow[a] : initWord(a);
  endfunction

  function automatic logic [31:0] mkAddr(input logic [TAG_W-1:0] t,
                                         input logic [INDEX_W-1:0] i,
                                         input logic [1:0] w);
    return {t, i, w, 2'b00};
  endfunction

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    waits = 0;
    #1;
    while (!cpuReady && waits < 300) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = cpuRdata;
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic doAccess(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input string rq);
    logic [TAG_W-1:0]   t = addr[31 -: TAG_W];
    logic [INDEX_W-1:0] ix = addr[OFF_W +: INDEX_W];
    logic [29:0]        wa = addr[31:2];
    logic               hitPred = refValid[ix] && (refTag[ix] == t);
    logic [31:0]        h0 = 32'(hitCount);
    logic [31:0]        m0 = 32'(missCount);
    logic [31:0]        r0 = rdCount;
    logic [31:0]        w0 = wrCount;
    logic [31:0]        rd;
    int                 waits;
    access(we, addr, wd, rd, waits);
    // R9: exactly one counter moves, and the right one
    check(32'(hitCount) == h0 + (hitPred ? 32'd1 : 32'd0) &&
          32'(missCount) == m0 + (hitPred ? 32'd0 : 32'd1),
          {rq, " R9 hit/miss classification"}, 32'(hitCount) - h0,
          hitPred ? 32'd1 : 32'd0);
    if (!hitPred) begin
      check(rdCount - r0 == 32'd4, "R3 fill read count", rdCount - r0, 32'd4);
      for (int k = 0; k < 4; k++)
        check(rdLog[k] == {t, ix, 2'(k)}, "R3 fill order/address",
              {2'b00, rdLog[k]}, {2'b00, t, ix, 2'(k)});
      check(waits >= 4 * (LAT + 1), "R6 stall covers whole fill", 32'(waits),
            32'(4 * (LAT + 1)));
    end else if (!we) begin
      check(waits == 0, "R2 hit answers at once", 32'(waits), 32'd0);
      check(rdCount == r0, "R2 hit makes no memory read", rdCount - r0, 32'd0);
    end
    if (!we) begin
      check(rd == expWord(wa), hitPred ? "R2 hit data" : "R3 miss data", rd, expWord(wa));
    end else begin
      check(wrCount - w0 == 32'd1, hitPred ? "R4 one write-through" : "R5 one write-through",
            wrCount - w0, 32'd1);
      check(memStore.exists(wa) && memStore[wa] == wd,
            hitPred ? "R4 memory holds store" : "R5 memory holds store",
            memStore.exists(wa) ? memStore[wa] : 32'hDEAD_BEEF, wd);
      shadow[wa] = wd;
    end
    refValid[ix] = 1'b1;
    refTag[ix]   = t;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LINES; i++) refValid[i] = 1'b0;
    #1;
    check(hitCount == '0 && missCount == '0, "R7 counters cleared",
          32'(hitCount) + 32'(missCount), 32'd0);
    check(!cpuReady && !memReq, "R7 idle after reset", {30'd0, cpuReady, memReq}, 32'd0);
  endtask

  initial begin : watchdog
    while (cycles < MAX_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, MAX_CYCLES);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stimulus
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] rd;
    int          waits;
    for (int i = 0; i < LINES; i++) begin refValid[i] = 1'b0; refTag[i] = '0; end
    doReset();

    // R1/R3: sweep all lines and words with tag 1; first word of each line misses
    for (int i = 0; i < LINES; i++)
      for (int w = 0; w < 4; w++)
        doAccess(1'b0, mkAddr(TAG_W'(1), INDEX_W'(i), 2'(w)), '0, "R1 sweep");

    // R1: conflicting tags on one line evict each other
    doAccess(1'b0, mkAddr(TAG_W'(2), 2'd0, 2'd2), '0, "R1 replacement");
    doAccess(1'b0, mkAddr(TAG_W'(1), 2'd0, 2'd2), '0, "R1 replacement back");
    doAccess(1'b0, mkAddr(TAG_W'(2), 2'd0, 2'd1), '0, "R1 replacement again");

    // R8: byte offset bits ignored
    doAccess(1'b0, mkAddr(TAG_W'(1), 2'd1, 2'd3) | 32'd3, '0, "R8 offset 3");
    doAccess(1'b0, mkAddr(TAG_W'(1), 2'd1, 2'd3) | 32'd1, '0, "R8 offset 1");

    // R4: store hits then read back
    doAccess(1'b1, mkAddr(TAG_W'(1), 2'd1, 2'd0), 32'h1111_0001, "R4 store hit");
    doAccess(1'b1, mkAddr(TAG_W'(1), 2'd3, 2'd3), 32'h1111_0003, "R4 store hit");
    doAccess(1'b0, mkAddr(TAG_W'(1), 2'd1, 2'd0), '0, "R4 readback");
    doAccess(1'b0, mkAddr(TAG_W'(1), 2'd3, 2'd3), '0, "R4 readback");

    // R5: store miss allocates, then whole line reads as memory plus merged word
    doAccess(1'b1, mkAddr(TAG_W'(5), 2'd2, 2'd1), 32'h5555_AAAA, "R5 store miss");
    for (int w = 0; w < 4; w++)
      doAccess(1'b0, mkAddr(TAG_W'(5), 2'd2, 2'(w)), '0, "R5 merged line");

    // R7: reset invalidates lines; previously cached line misses
    doReset();
    doAccess(1'b0, mkAddr(TAG_W'(5), 2'd2, 2'd1), '0, "R7 miss after reset");
    doAccess(1'b0, mkAddr(TAG_W'(5), 2'd2, 2'd1), '0, "R7 hit after refill");

    // mixed pseudo-random traffic over four tags and all lines
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doAccess(lfsr[0] & lfsr[5],
               mkAddr(TAG_W'(lfsr[3:2]), INDEX_W'(lfsr[9:8]), lfsr[12:11]) | {30'd0, lfsr[7:6]},
               {lfsr, ~lfsr}, "R1 mixed");
    end

    check(holdViol == 32'd0, "R10 memory request held until acknowledge", holdViol, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule